// File: doc/BRIEF.md
# Serial Bus Clock Divider

This block turns a fast core clock into the slow clock of a two-wire serial bus. The division runs through four stages in a fixed order. First comes a pre-divide set per instance, then a fixed divide by ten, then a power-of-two stage chosen by a 3-bit code N. The last stage divides by (M + offset), where M is a 4-bit code and the offset is set per instance. The output period in core cycles is PRE_DIV * 10 * 2^N * (M + M_OFFSET).

Software writes one 7-bit field that packs M and N, and reads it back unchanged so it can recompute the rate. The output is a 50% duty square wave. A one-cycle enable pulse marks each rising edge. A new setting waits for the current half period to end, so the bus never sees a shortened high or low phase. A setting whose divisor is zero parks the clock low.

Top module: `serial_clk_divider`

## Requirements
- R1: The period of `sclk_o`, counted in `clk` cycles, is PRE_DIV * 10 * 2^N * (M + M_OFFSET). PRE_DIV and M_OFFSET are fixed parameters.
- R2: The field packs N into bits [2:0] and M into bits [6:3]. Writing 7'h5B (M=11, N=3) with PRE_DIV=1 and M_OFFSET=0 gives a period of 880 cycles.
- R3: `sclk_o` is high for exactly half of each period and low for the other half.
- R4: In the cycle after a write, `cfg_rd_data` returns the written value bit for bit.
- R5: A write changes the output only at the end of the half period in progress. That half period keeps its old length, and the next one uses the new length.
- R6: Reset clears the field to zero and drives `sclk_o` and `tick_o` low. It restarts every stage counter, so with PRE_DIV=3 and M_OFFSET=2 the first rising edge comes exactly 30 cycles after reset is released.
- R7: While the active divisor (M + M_OFFSET) is zero, `sclk_o` stays low and `tick_o` never pulses.
- R8: `tick_o` is high for one cycle, in the cycle in which `sclk_o` has just risen, and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the divider field |
| cfg_wr_data | input | 7 | New field value: M in [6:3], N in [2:0] |
| cfg_rd_data | output | 7 | Field as last written |
| sclk_o | output | 1 | Divided square-wave clock, 50% duty |
| tick_o | output | 1 | One-cycle pulse at each rising edge of `sclk_o` |

## Verification
The bench builds two instances. The first uses PRE_DIV=1 and M_OFFSET=0. This keeps periods short enough to measure many M/N codes cycle by cycle, and it is the only setting that reaches a zero divisor, both straight out of reset and after a write. The second uses PRE_DIV=3 and M_OFFSET=2. With it, the pre-divide and offset terms change the measured period, so a stage wired with the wrong limit gives a different count. The second instance also gives an exact count from reset release to the first rising edge.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  localparam int unsigned N_W     = 3;
  localparam int unsigned M_W     = 4;
  localparam int unsigned FIELD_W = N_W + M_W;
  localparam int unsigned P2_W    = 7;   // wide enough for 2^7 - 1
  localparam int unsigned DEC_DIV = 5;   // the /10 is /5 here and /2 in the toggle flop

  typedef struct packed {
    logic [M_W-1:0] m;   // bits [6:3]
    logic [N_W-1:0] n;   // bits [2:0]
  } sdiv_field_t;

  // Last count of the power-of-two stage: 2^n - 1.
  function automatic logic [P2_W-1:0] pow2_last(input logic [N_W-1:0] n);
    logic [P2_W:0] one_hot;
    one_hot = (P2_W+1)'(1) << n;
    return P2_W'(one_hot - (P2_W+1)'(1));
  endfunction

  // Divisor of the final stage: M plus the instance offset.
  function automatic int unsigned div_of(input logic [M_W-1:0] m, input int unsigned off);
    return 32'(m) + off;
  endfunction

endpackage

// File: rtl/sdiv_stage.sv
module sdiv_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] last,
  output logic         wrap
);

  logic [W-1:0] cnt;

  assign wrap = en && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en)     cnt <= wrap ? '0 : cnt + W'(1);
  end

endmodule

// File: rtl/sdiv_field.sv
module sdiv_field
  import sdiv_pkg::*;
#(
  parameter int unsigned M_OFFSET = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic               term_evt,
  output sdiv_field_t        field_o,
  output sdiv_field_t        act_o,
  output logic               act_zero_o,
  output logic               new_zero_o
);

  sdiv_field_t field_q, act_q;
  logic        load;

  assign act_zero_o = (div_of(act_q.m, M_OFFSET) == 0);
  assign new_zero_o = (div_of(field_q.m, M_OFFSET) == 0);
  // The active copy is taken over at a half-period boundary, or at once when parked.
  assign load       = term_evt || act_zero_o;

  always_ff @(posedge clk) begin
    if (!rst_n)     field_q <= '0;
    else if (wr_en) field_q <= sdiv_field_t'(wr_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    act_q <= '0;
    else if (load) act_q <= field_q;
  end

  assign field_o = field_q;
  assign act_o   = act_q;

endmodule

// File: rtl/serial_clk_divider.sv
module serial_clk_divider
  import sdiv_pkg::*;
#(
  parameter int unsigned PRE_DIV  = 2,
  parameter int unsigned M_OFFSET = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [FIELD_W-1:0] cfg_wr_data,
  output logic [FIELD_W-1:0] cfg_rd_data,
  output logic               sclk_o,
  output logic               tick_o
);

  localparam int unsigned DIV_MAX = (1 << M_W) - 1 + M_OFFSET;
  localparam int unsigned DIV_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX + 1) : 1;
  localparam int unsigned PRE_W   = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  sdiv_field_t        field, act;
  logic               act_zero, new_zero;
  logic [FIELD_W-1:0] act_cfg;
  logic               pre_tick, dec_tick, p2_tick, fin_tick;
  logic               term_evt;
  logic [P2_W-1:0]    p2_last;
  logic [DIV_W-1:0]   fin_last;
  logic               sclk_q, tick_q;

  sdiv_field #(.M_OFFSET(M_OFFSET)) u_field (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_data    (cfg_wr_data),
    .term_evt   (term_evt),
    .field_o    (field),
    .act_o      (act),
    .act_zero_o (act_zero),
    .new_zero_o (new_zero)
  );

  assign act_cfg  = act;
  assign p2_last  = pow2_last(act.n);
  assign fin_last = DIV_W'(div_of(act.m, M_OFFSET) - 32'd1);

  generate
    if (PRE_DIV > 1) begin : g_pre
      sdiv_stage #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(act_zero), .en(!act_zero),
        .last(PRE_W'(PRE_DIV - 1)), .wrap(pre_tick)
      );
    end else begin : g_no_pre
      assign pre_tick = !act_zero;
    end
  endgenerate

  sdiv_stage #(.W(3)) u_dec (
    .clk(clk), .rst_n(rst_n), .clr(act_zero), .en(pre_tick),
    .last(3'(DEC_DIV - 1)), .wrap(dec_tick)
  );

  sdiv_stage #(.W(P2_W)) u_p2 (
    .clk(clk), .rst_n(rst_n), .clr(act_zero), .en(dec_tick),
    .last(p2_last), .wrap(p2_tick)
  );

  sdiv_stage #(.W(DIV_W)) u_fin (
    .clk(clk), .rst_n(rst_n), .clr(act_zero), .en(p2_tick),
    .last(fin_last), .wrap(fin_tick)
  );

  // End of a half period: every counter wraps to zero together here.
  assign term_evt = fin_tick && !act_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= term_evt && !sclk_q && !new_zero;
      if (term_evt) sclk_q <= new_zero ? 1'b0 : !sclk_q;
    end
  end

  assign cfg_rd_data = field;
  assign sclk_o      = sclk_q;
  assign tick_o      = tick_q;

endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr_en,
  input logic [6:0] cfg_wr_data,
  input logic [6:0] cfg_rd_data,
  input logic       sclk_o,
  input logic       tick_o,
  input logic       term_evt,
  input logic       act_zero,
  input logic [6:0] act_cfg
);

  AST_RDBK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (cfg_rd_data == $past(cfg_wr_data)));  // R4

  AST_TICK_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (sclk_o && !$past(sclk_o)));  // R8

  AST_RISE_HAS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && !$past(sclk_o)) |-> tick_o);  // R8

  AST_EDGE_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o != $past(sclk_o)) |-> $past(term_evt));  // R5

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!term_evt && !act_zero) |=> $stable(act_cfg));  // R5

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    act_zero |-> (!sclk_o && !tick_o));  // R7

endmodule

bind serial_clk_divider sdiv_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .sclk_o      (sclk_o),
  .tick_o      (tick_o),
  .term_evt    (term_evt),
  .act_zero    (act_zero),
  .act_cfg     (act_cfg)
);

// File: tb/serial_clk_divider_tb.sv
module serial_clk_divider_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_a_en = 1'b0, wr_b_en = 1'b0;
  logic [6:0] wr_a_d = '0, wr_b_d = '0;
  logic [6:0] rd_a, rd_b;
  logic       sclk_a, sclk_b, tick_a, tick_b;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Instance A: PRE_DIV=1, M_OFFSET=0
  serial_clk_divider #(.PRE_DIV(1), .M_OFFSET(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_a_en), .cfg_wr_data(wr_a_d),
    .cfg_rd_data(rd_a), .sclk_o(sclk_a), .tick_o(tick_a)
  );

  // Instance B: PRE_DIV=3, M_OFFSET=2
  serial_clk_divider #(.PRE_DIV(3), .M_OFFSET(2)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_b_en), .cfg_wr_data(wr_b_d),
    .cfg_rd_data(rd_b), .sclk_o(sclk_b), .tick_o(tick_b)
  );

  typedef struct packed {
    logic        sel;
    logic [6:0]  fld;
    logic [15:0] per;
  } vec_t;

  // period = PRE_DIV * 10 * 2^N * (M + M_OFFSET), field = {M, N}
  localparam vec_t VECS [10] = '{
    '{1'b0, 7'h08, 16'd10},    // M1 N0
    '{1'b0, 7'h18, 16'd30},    // M3 N0
    '{1'b0, 7'h0A, 16'd40},    // M1 N2
    '{1'b0, 7'h29, 16'd100},   // M5 N1
    '{1'b0, 7'h78, 16'd150},   // M15 N0
    '{1'b0, 7'h13, 16'd160},   // M2 N3
    '{1'b0, 7'h0F, 16'd1280},  // M1 N7
    '{1'b1, 7'h01, 16'd120},   // B: M0 N1 -> 3*10*2*2
    '{1'b1, 7'h08, 16'd90},    // B: M1 N0 -> 3*10*1*3
    '{1'b1, 7'h22, 16'd720}    // B: M4 N2 -> 3*10*4*6
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sclk_of(input bit sel);
    return sel ? sclk_b : sclk_a;
  endfunction

  function automatic logic tick_of(input bit sel);
    return sel ? tick_b : tick_a;
  endfunction

  task automatic wr(input bit sel, input logic [6:0] d);
    if (sel) begin wr_b_en = 1'b1; wr_b_d = d; end
    else     begin wr_a_en = 1'b1; wr_a_d = d; end
    @(negedge clk);
    wr_a_en = 1'b0;
    wr_b_en = 1'b0;
    chk("R4 readback", int'(sel ? rd_b : rd_a), int'(d));
  endtask

  task automatic wait_rise(input bit sel);
    logic p, c;
    p = sclk_of(sel);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      c = sclk_of(sel);
      if (!p && c) return;
      p = c;
    end
  endtask

  // Starts at the next rising edge, ends at the one after.
  task automatic measure(input bit sel, output int hi, output int lo, output int ticks);
    wait_rise(sel);
    ticks = tick_of(sel) ? 1 : 0;
    hi = 1;
    lo = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (tick_of(sel)) ticks++;
      if (sclk_of(sel)) hi++;
      else break;
    end
    lo = 1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!sclk_of(sel)) begin
        lo++;
        if (tick_of(sel)) ticks++;
      end else break;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int hi, lo, tk, cnt, viol;

    // R6: reset state
    repeat (5) @(negedge clk);
    chk("R6 field A after reset", int'(rd_a), 0);
    chk("R6 field B after reset", int'(rd_b), 0);
    chk("R6 outputs low in reset", int'({sclk_a, sclk_b, tick_a, tick_b}), 0);

    // R6: counters restart; B's first rise lands 3*5*1*2 = 30 cycles after release
    rst_n = 1'b1;
    cnt = 0;
    viol = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      cnt++;
      if (sclk_a || tick_a) viol++;
      if (sclk_b) break;
    end
    chk("R6 first rise after release", cnt, 30);
    chk("R7 A parked low with zero divisor out of reset", viol, 0);

    // R2: field packing, 7'h5B = M11 N3 -> 10*8*11
    wr(1'b0, 7'h5B);
    wait_rise(1'b0);
    measure(1'b0, hi, lo, tk);
    chk("R2 period for M11 N3", hi + lo, 880);

    // R1 R3 R8: table of vectors
    foreach (VECS[k]) begin
      wr(VECS[k].sel, VECS[k].fld);
      wait_rise(VECS[k].sel);
      measure(VECS[k].sel, hi, lo, tk);
      chk("R1 period", hi + lo, int'(VECS[k].per));
      chk("R3 high half", hi, int'(VECS[k].per) / 2);
      chk("R3 low half", lo, int'(VECS[k].per) / 2);
      chk("R8 one tick per period", tk, 1);
    end

    // R5: a half period in progress keeps its length after a write
    wr(1'b0, 7'h78);   // M15 N0 -> half 75
    wait_rise(1'b0);
    wait_rise(1'b0);
    hi = 1;
    repeat (10) begin
      @(negedge clk);
      if (sclk_a) hi++;
    end
    wr_a_en = 1'b1;
    wr_a_d  = 7'h08;   // M1 N0 -> half 5
    @(negedge clk);
    wr_a_en = 1'b0;
    if (sclk_a) hi++;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (sclk_a) hi++;
      else break;
    end
    lo = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!sclk_a) lo++;
      else break;
    end
    chk("R5 old high phase completes", hi, 75);
    chk("R5 next phase uses new setting", lo, 5);

    // R7: zero divisor written at run time parks the output low
    wr(1'b0, 7'h02);   // M0 N2, offset 0 -> divisor 0
    repeat (40) @(negedge clk);
    viol = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sclk_a || tick_a) viol++;
    end
    chk("R7 output parked low", viol, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule